// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block is the register file of a general-purpose I/O controller serving 95 pins. A simple 32-bit register bus reaches it through an address, a write strobe, write data and registered read data. Every pin owns two 32-bit configuration words. The first word holds the pin's function select, direction, trigger-type fields, drive level and sampled input level. The second word holds an input-sensing gate and a weak-pull choice. Three further maps pack one bit per pin into consecutive 32-bit words: a firmware-ownership map, an interrupt-routing map and an interrupt-enable map.

The configuration is decoded into pad controls: a drive value, a drive enable and pull-up and pull-down requests. Raw pad inputs are resynchronised by two flops before software can read them. Interrupt detection, alternate native functions and the analog pad itself belong to neighbouring blocks. As a result, the status map region is present in the address space but always reads zero.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset, every pin's first word reads 0x0000_0005 (GPIO mode, input, level 0, trigger fields 0). Every second word reads 0x0000_0004 (sensing off, no pull). Every valid ownership bit reads 1, the routing and enable maps read 0, and all pad drive enables and pull requests are 0.
- R2: First word layout: bit 31 drive level (read/write), bit 30 input level (read-only), bit 4 trigger select, bit 3 trigger invert, bit 2 direction (1 input, 0 output) and bits 1:0 function select (0 native, 1 GPIO). All other bits read 0, and writes to them or to bit 30 are ignored.
- R3: Second word layout: bit 2 set turns input sensing off, and bits 1:0 select the weak pull (0 none, 1 down, 2 up). All other bits read 0.
- R4: Pin n's first word is at byte address 0x100 + 8n and its second word at 0x104 + 8n. Address bits 1:0 are ignored. A write to one pin leaves every other pin unchanged.
- R5: The ownership map is based at 0x00, the routing map at 0x10 and the enable map at 0x90. Pin n sits in the word at base + 4·(n/32), bit n mod 32. Bit 31 of each map's third word has no pin, so it reads 0 and ignores writes.
- R6: The status map region at 0x80 reads 0 and ignores writes.
- R7: Addresses past pin 94's second word, and the fourth word of any map region, read 0. Writes to them change no state.
- R8: A pin's drive enable is 1 only while its function select is 1 and its direction bit is 0. Its drive value always equals first-word bit 31.
- R9: Pull-down is requested when the pull field is 1 and pull-up when it is 2. The two requests are never active together.
- R10: Pad inputs pass through two synchronizing flops. The input level bit shows the synchronized value while sensing is on and reads 0 while it is off, whatever the direction.
- R11: Read data is registered. It returns the addressed word one clock edge after the address is presented, with the register contents from before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Byte address of the accessed word |
| wrEn | input | 1 | Write strobe for the addressed word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| padIn | input | 95 | Raw pad input levels |
| padOut | output | 95 | Drive value per pad |
| padOe | output | 95 | Drive enable per pad |
| pullUp | output | 95 | Weak pull-up request per pad |
| pullDown | output | 95 | Weak pull-down request per pad |

## Verification
Read data for an address presented in one cycle is due at the next rising edge. The scoreboard therefore queues each expected word as the read is driven and retires it just after that edge. Pad controls follow a write by one edge, and the bench samples them at the falling edge that follows. A pad input change first becomes visible in read data issued two cycles after the change. The bench issues three back-to-back reads at that moment and expects the old, old and new levels. It then waits a settled interval before every other input-level check.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  // Address map, in bytes
  localparam int CFG_BASE_OFS   = 32'h100;
  localparam int REG_PAIR_BYTES = 8;
  localparam int OWN_OFS        = 32'h00;
  localparam int ROUTE_OFS      = 32'h10;
  localparam int IRQEN_OFS      = 32'h90;

  // Pin index width; a map region spans four words, so at most 128 pins
  localparam int MAX_PIN_W = 7;

  // First word field positions
  localparam int C1_OUT_BIT  = 31;
  localparam int C1_IN_BIT   = 30;
  localparam int C1_TRIG_BIT = 4;
  localparam int C1_INV_BIT  = 3;
  localparam int C1_DIR_BIT  = 2;
  // Second word field positions
  localparam int C2_SENSE_OFF_BIT = 2;

  localparam logic [1:0] USE_GPIO  = 2'd1;
  localparam logic [1:0] PULL_DOWN = 2'd1;
  localparam logic [1:0] PULL_UP   = 2'd2;

  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic                 wr;
    logic                 own;
    logic                 route;
    logic                 irqEn;
    logic                 cfg1;
    logic                 cfg2;
    logic [MAX_PIN_W-1:0] pin;
    logic [1:0]           word;
  } accT;
endpackage

// File: rtl/gpio_cfg_decode.sv
module gpio_cfg_decode
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output accT               acc
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int TAG_W     = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] CfgBase = ADDR_W'(CFG_BASE_OFS);
  localparam logic [ADDR_W-1:0] CfgEnd  = ADDR_W'(CFG_BASE_OFS + NUM_PINS * REG_PAIR_BYTES);
  localparam logic [TAG_W-1:0]  OwnTag   = TAG_W'(OWN_OFS / 16);
  localparam logic [TAG_W-1:0]  RouteTag = TAG_W'(ROUTE_OFS / 16);
  localparam logic [TAG_W-1:0]  IrqEnTag = TAG_W'(IRQEN_OFS / 16);

  logic [ADDR_W-1:0] cfgOff;
  logic              unusedOffBits;

  assign cfgOff        = addr - CfgBase;
  assign unusedOffBits = ^{cfgOff[1:0], cfgOff[ADDR_W-1:MAX_PIN_W+3]};

  always_comb begin
    acc      = '0;
    acc.wr   = wrEn;
    acc.word = addr[3:2];
    if (addr >= CfgBase && addr < CfgEnd) begin
      acc.pin  = cfgOff[MAX_PIN_W+2:3];
      acc.cfg2 = cfgOff[2];
      acc.cfg1 = ~cfgOff[2];
    end else if (int'(addr[3:2]) < NUM_WORDS) begin
      acc.own   = (addr[ADDR_W-1:4] == OwnTag);
      acc.route = (addr[ADDR_W-1:4] == RouteTag);
      acc.irqEn = (addr[ADDR_W-1:4] == IrqEnTag);
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 95
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= rawIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 95
) (
  input  logic                clk,
  input  logic                rst,
  input  accT                 acc,
  input  logic [31:0]         wrData,
  input  logic [NUM_PINS-1:0] syncLvl,
  output logic [31:0]         rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] pullUp,
  output logic [NUM_PINS-1:0] pullDown
);
  logic [NUM_PINS-1:0] ownMap, routeMap, irqEnMap;
  logic [NUM_PINS-1:0] outLvl, trigSel, trigInv, dirIn, senseOff;
  logic [1:0]          useSel [NUM_PINS];
  logic [1:0]          pullSel[NUM_PINS];
  logic [NUM_PINS-1:0] selMap;
  logic [31:0]         rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      ownMap   <= '1;
      routeMap <= '0;
      irqEnMap <= '0;
      outLvl   <= '0;
      trigSel  <= '0;
      trigInv  <= '0;
      dirIn    <= '1;
      senseOff <= '1;
      for (int p = 0; p < NUM_PINS; p++) begin
        useSel[p]  <= USE_GPIO;
        pullSel[p] <= 2'd0;
      end
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (acc.wr && acc.word == 2'(p / 32)) begin
          if (acc.own)   ownMap[p]   <= wrData[p % 32];
          if (acc.route) routeMap[p] <= wrData[p % 32];
          if (acc.irqEn) irqEnMap[p] <= wrData[p % 32];
        end
        if (acc.wr && acc.pin == MAX_PIN_W'(p)) begin
          if (acc.cfg1) begin
            outLvl[p]  <= wrData[C1_OUT_BIT];
            trigSel[p] <= wrData[C1_TRIG_BIT];
            trigInv[p] <= wrData[C1_INV_BIT];
            dirIn[p]   <= wrData[C1_DIR_BIT];
            useSel[p]  <= wrData[1:0];
          end
          if (acc.cfg2) begin
            senseOff[p] <= wrData[C2_SENSE_OFF_BIT];
            pullSel[p]  <= wrData[1:0];
          end
        end
      end
    end
  end

  // Pad-facing decode
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      padOut[p]   = outLvl[p];
      padOe[p]    = (useSel[p] == USE_GPIO) && !dirIn[p];
      pullUp[p]   = (pullSel[p] == PULL_UP);
      pullDown[p] = (pullSel[p] == PULL_DOWN);
    end
  end

  // Read mux
  always_comb begin
    selMap = acc.own ? ownMap : acc.route ? routeMap : acc.irqEn ? irqEnMap : '0;
    rdNext = '0;
    if (acc.cfg1) begin
      rdNext[C1_OUT_BIT]  = outLvl[acc.pin];
      rdNext[C1_IN_BIT]   = syncLvl[acc.pin] & ~senseOff[acc.pin];
      rdNext[C1_TRIG_BIT] = trigSel[acc.pin];
      rdNext[C1_INV_BIT]  = trigInv[acc.pin];
      rdNext[C1_DIR_BIT]  = dirIn[acc.pin];
      rdNext[1:0]         = useSel[acc.pin];
    end else if (acc.cfg2) begin
      rdNext[C2_SENSE_OFF_BIT] = senseOff[acc.pin];
      rdNext[1:0]              = pullSel[acc.pin];
    end else begin
      for (int b = 0; b < 32; b++) begin
        if (int'(acc.word) * 32 + b < NUM_PINS)
          rdNext[b] = selMap[MAX_PIN_W'(int'(acc.word) * 32 + b)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= rdNext;
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] pullUp,
  output logic [NUM_PINS-1:0] pullDown
);
  accT                 acc;
  logic [NUM_PINS-1:0] syncLvl;

  gpio_cfg_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
    .addr(addr), .wrEn(wrEn), .acc(acc)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .rawIn(padIn), .syncOut(syncLvl)
  );

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .acc(acc), .wrData(wrData), .syncLvl(syncLvl),
    .rdData(rdData), .padOut(padOut), .padOe(padOe),
    .pullUp(pullUp), .pullDown(pullDown)
  );
endmodule

// File: rtl/gpio_cfg_bank_chk.sv
module gpio_cfg_bank_chk
  import gpio_cfg_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   addr,
  input logic                wrEn,
  input logic [31:0]         wrData,
  input logic [31:0]         rdData,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] syncLvl,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] pullUp,
  input logic [NUM_PINS-1:0] pullDown
);
  localparam logic [ADDR_W-1:0] CfgBase = ADDR_W'(CFG_BASE_OFS);
  localparam logic [ADDR_W-1:0] CfgEnd  = ADDR_W'(CFG_BASE_OFS + NUM_PINS * REG_PAIR_BYTES);

  assert_oob_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (addr >= CfgEnd) |=> (rdData == 32'd0));

  assert_oob_write_inert_R7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr >= CfgEnd) |=>
      ($stable(padOe) && $stable(padOut) && $stable(pullUp) && $stable(pullDown)));

  assert_gpio_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == CfgBase && wrData[2:0] == 3'b001) |=>
      (padOe[0] && padOut[0] == $past(wrData[31])));

  assert_native_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == CfgBase && wrData[1:0] == 2'b00) |=> !padOe[0]);

  assert_pull_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    (pullUp & pullDown) == '0);

  assert_sync_depth_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (syncLvl == $past(padIn, 2)));
endmodule

bind gpio_cfg_bank gpio_cfg_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .padIn(padIn), .syncLvl(syncLvl), .padOut(padOut), .padOe(padOe),
  .pullUp(pullUp), .pullDown(pullDown)
);

// File: tb/test_gpio_cfg_bank.sv
module test_gpio_cfg_bank;
  localparam int PERIOD   = 10;
  localparam int NUM_PINS = 95;
  localparam int ADDR_W   = 12;

  logic                clk = 1'b0;
  logic                rst;
  logic [ADDR_W-1:0]   addr;
  logic                wrEn;
  logic [31:0]         wrData;
  logic [31:0]         rdData;
  logic [NUM_PINS-1:0] padIn;
  logic [NUM_PINS-1:0] padOut, padOe, pullUp, pullDown;

  int nChecks = 0;
  int nBad    = 0;
  bit doneFlag = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expT;
  expT expQ[$];

  always #(PERIOD / 2) clk = ~clk;

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_gpio_cfg_bank (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .pullUp(pullUp), .pullDown(pullDown)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  // Driver tasks: called at a falling edge, drive, then wait for the next one
  task automatic doRead(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    expT it;
    addr = a; wrEn = 1'b0; wrData = '0;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic doWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    addr = a; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doWriteOld(logic [ADDR_W-1:0] a, logic [31:0] d, logic [31:0] expOld, string tag);
    expT it;
    addr = a; wrEn = 1'b1; wrData = d;
    it.exp = expOld; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    addr = 12'hFFC; wrEn = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
    expQ.delete();
  endtask

  // Monitor: retire one expected read just after each rising edge
  initial begin
    forever begin
      expT it;
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        check(it.tag, rdData, it.exp);
      end
    end
  end

  // Watchdog
  initial begin
    #(PERIOD * 100000);
    nChecks++;
    nBad++;
    $display("watchdog expired, run hung");
    summary();
  end

  initial begin
    rst = 1'b1; addr = '0; wrEn = 1'b0; wrData = '0; padIn = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 padOe", 32'(padOe != '0), 32'd0);
    check("R1 pulls", 32'((pullUp | pullDown) != '0), 32'd0);
    check("R1 padOut", 32'(padOut != '0), 32'd0);
    doRead(12'h100, 32'h0000_0005, "R1 pin0 word1 (R10 sensing off)");
    doRead(12'h104, 32'h0000_0004, "R1 pin0 word2");
    doRead(12'h3F0, 32'h0000_0005, "R1 pin94 word1");
    doRead(12'h000, 32'hFFFF_FFFF, "R1 ownership word0");
    doRead(12'h008, 32'h7FFF_FFFF, "R1 R5 ownership word2 spare bit");
    doRead(12'h010, 32'h0000_0000, "R1 routing word0");

    // R2 first word layout, R4 isolation
    doWrite(12'h100, 32'hFFFF_FFFF);
    doRead(12'h100, 32'h8000_001F, "R2 all-ones write");
    check("R8 padOe use=3", 32'(padOe[0]), 32'd0);
    check("R8 padOut", 32'(padOut[0]), 32'd1);
    doRead(12'h108, 32'h0000_0005, "R4 pin1 untouched");
    doRead(12'h103, 32'h8000_001F, "R4 low address bits ignored");

    // R8 drive enable
    doWrite(12'h100, 32'h8000_0001);
    check("R8 padOe gpio out", 32'(padOe[0]), 32'd1);
    check("R8 padOut high", 32'(padOut[0]), 32'd1);
    doWrite(12'h100, 32'h0000_0000);
    check("R8 padOe native", 32'(padOe[0]), 32'd0);
    check("R8 padOut low", 32'(padOut[0]), 32'd0);
    doWrite(12'h100, 32'h0000_0005);
    check("R8 padOe input", 32'(padOe[0]), 32'd0);
    doWrite(12'h100, 32'h0000_0001);
    check("R8 padOe gpio out low", 32'(padOe[0]), 32'd1);

    // R3 / R9 second word and pulls
    doWrite(12'h104, 32'h0000_0001);
    check("R9 pullDown", 32'({pullUp[0], pullDown[0]}), 32'd1);
    doRead(12'h104, 32'h0000_0001, "R3 pull-down read");
    doWrite(12'h104, 32'hFFFF_FFFA);
    check("R9 pullUp", 32'({pullUp[0], pullDown[0]}), 32'd2);
    doRead(12'h104, 32'h0000_0002, "R3 reserved bits dropped");

    // R10 synchronizer depth, sensing enabled on pin0
    doRead(12'h100, 32'h4000_0001, "R10 settled high");
    padIn[0] = 1'b0;
    doRead(12'h100, 32'h4000_0001, "R10 edge +1 old");
    doRead(12'h100, 32'h4000_0001, "R10 edge +2 old");
    doRead(12'h100, 32'h0000_0001, "R10 edge +3 new");
    doWrite(12'h104, 32'h0000_0004);
    padIn[0] = 1'b1;
    idle(3);
    doRead(12'h100, 32'h0000_0001, "R10 sensing off reads 0");
    doWrite(12'h3F4, 32'h0000_0000);
    idle(2);
    doRead(12'h3F0, 32'h4000_0005, "R10 pin94 input level");

    // R5 bitmaps
    doWrite(12'h000, 32'h0000_0000);
    doRead(12'h000, 32'h0000_0000, "R5 ownership word0 cleared");
    doRead(12'h004, 32'hFFFF_FFFF, "R5 ownership word1 intact");
    doWrite(12'h018, 32'hFFFF_FFFF);
    doRead(12'h018, 32'h7FFF_FFFF, "R5 routing word2 spare bit");
    doRead(12'h010, 32'h0000_0000, "R5 routing word0 intact");
    doWrite(12'h094, 32'h1234_5678);
    doRead(12'h094, 32'h1234_5678, "R5 enable word1");
    doRead(12'h090, 32'h0000_0000, "R5 enable word0 intact");

    // R6 status region, R7 out of range
    doWrite(12'h080, 32'hFFFF_FFFF);
    doRead(12'h080, 32'h0000_0000, "R6 status reads 0");
    doWrite(12'h3F8, 32'hFFFF_FFFF);
    doRead(12'h3F8, 32'h0000_0000, "R7 past last pin");
    doRead(12'h3F0, 32'h4000_0005, "R7 pin94 unchanged");
    check("R7 padOe unchanged", 32'(padOe[94]), 32'd0);
    doWrite(12'h00C, 32'h0000_0000);
    doRead(12'h00C, 32'h0000_0000, "R7 fourth map word");
    doRead(12'h008, 32'h7FFF_FFFF, "R7 ownership word2 intact");

    // R11 read-during-write returns old contents
    doWriteOld(12'h108, 32'h8000_0001, 32'h0000_0005, "R11 old value on write");
    doRead(12'h108, 32'h8000_0001, "R11 new value after write");
    check("R8 pin1 padOe", 32'(padOe[1]), 32'd1);
    check("R8 pin1 padOut", 32'(padOut[1]), 32'd1);

    idle(2);
    summary();
  end
endmodule